// File: doc/BRIEF.md
# Last-Outcome Branch Direction Predictor

This block guesses whether a branch will be taken. A fetch stage presents a lookup carrying the branch address, the branch target and a flag that marks the branch as conditional. The block answers with a taken or not-taken guess in the same cycle, through combinational logic only. Later, an execute stage reports the branch address and the real direction, and the block records that direction in a small history table.

The table is direct-mapped and tagged. Each slot holds a valid bit, an address tag and one bit holding the most recent direction. Unconditional branches are always guessed taken and never touch the table. A conditional branch that finds its own slot is guessed the way it went last time. A conditional branch that finds no matching slot uses a fixed rule: a branch that jumps to a lower address is guessed taken, and any other branch is guessed not taken.

Top module: `branch_hint_unit`

## Requirements
- R1: A valid lookup with `lk_cond` low drives `lk_taken` high, whatever its addresses and whatever the table holds.
- R2: A valid conditional lookup that hits the table drives `lk_taken` to the direction recorded by the latest conditional resolve of that exact address.
- R3: A valid conditional lookup that misses drives `lk_taken` high when `lk_target` is below `lk_pc` as an unsigned number, and low otherwise. A target equal to the branch address counts as not taken.
- R4: The slot index is `pc[IDX_W-1:0]` and the tag is `pc[ADDR_W-1:IDX_W]`, with `IDX_W = log2(ENTRIES)`. A hit needs the slot's valid bit set and its tag equal to the lookup tag.
- R5: A resolve with `rs_valid` and `rs_cond` high writes the valid bit, tag and direction into its slot. Whatever held that slot before is replaced, so a branch with another tag that shares the index then misses.
- R6: A resolve with `rs_cond` low changes no slot. A later conditional lookup of that address still follows the state the slot had before.
- R7: Holding `rst_n` low across a rising edge clears every valid bit, so every conditional lookup afterwards uses the R3 rule until a new resolve arrives.
- R8: When a lookup and a resolve hit the same slot in one cycle, the lookup returns the old state. The new state is seen from the next cycle on.
- R9: With `lk_valid` low, `lk_taken` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | ADDR_W | Address of the branch being looked up |
| lk_target | input | ADDR_W | Target address of that branch |
| lk_cond | input | 1 | High when the looked-up branch is conditional |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | Resolve report present |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_cond | input | 1 | High when the resolved branch is conditional |
| rs_taken | input | 1 | Real direction of the resolved branch |

## Verification
The prediction is combinational, so it is due in the same cycle as the lookup. A resolve becomes visible one rising edge later. The bench drives its inputs on the falling edge and samples `lk_taken` one time unit later, before the next rising edge. It then applies any resolve to its reference table on that rising edge. This means each check sees exactly the table state left by earlier edges, and the same-cycle case of R8 is checked at the point where the old state must still hold.

// File: rtl/bhu_pkg.sv
// Package: shared types of the branch hint unit.
// Assumes: nothing beyond IEEE 1800-2017.
package bhu_pkg;

    // Which rule produced a prediction.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_UNCOND = 2'd1,
        SRC_TABLE  = 2'd2,
        SRC_STATIC = 2'd3
    } pred_src_e;

endpackage

// File: rtl/bhu_history_table.sv
// Module: direct-mapped, tagged table of last branch directions.
// One combinational read port and one write port that takes effect on
// the rising edge. A same-cycle read therefore sees the old contents.
// Assumes: ENTRIES is a power of two, at least 2, and below 2**ADDR_W.
module bhu_history_table #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output logic              rd_dir,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic              wr_dir
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ENTRIES-1:0] slot_valid;
    logic [ENTRIES-1:0] slot_dir;
    logic [TAG_W-1:0]   slot_tag [ENTRIES];

    logic [IDX_W-1:0] rd_idx;
    logic [TAG_W-1:0] rd_tag;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;

    // Split both addresses into index and tag.
    always_comb begin
        rd_idx = rd_pc[IDX_W-1:0];
        rd_tag = rd_pc[ADDR_W-1:IDX_W];
        wr_idx = wr_pc[IDX_W-1:0];
        wr_tag = wr_pc[ADDR_W-1:IDX_W];
    end

    // Read port: a hit needs a valid slot and a matching tag.
    always_comb begin
        rd_hit = slot_valid[rd_idx] && (slot_tag[rd_idx] == rd_tag);
        rd_dir = slot_dir[rd_idx];
    end

    // Valid bits: cleared by reset, set by every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= '0;
        end else if (wr_en) begin
            slot_valid[wr_idx] <= 1'b1;
        end
    end

    // Tag and direction payload of each slot, one generated register per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_tag[g] <= '0;
                slot_dir[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_tag[g] <= wr_tag;
                slot_dir[g] <= wr_dir;
            end
        end
    end

endmodule

// File: rtl/bhu_static_hint.sv
// Module: fixed fallback rule used when the table has no entry.
// A backward branch (target strictly below the branch address, unsigned)
// is guessed taken. Everything else is guessed not taken.
// Assumes: addresses are unsigned.
module bhu_static_hint #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    output logic              backward
);
    // Unsigned compare of target against branch address.
    always_comb begin
        backward = (target < pc);
    end

endmodule

// File: rtl/bhu_select.sv
// Module: picks the rule that produces the prediction.
// Priority: no request, then unconditional, then table hit, then static rule.
// Assumes: the inputs are settled combinationally in the same cycle.
module bhu_select
    import bhu_pkg::*;
(
    input  logic lk_valid,
    input  logic lk_cond,
    input  logic tbl_hit,
    input  logic tbl_dir,
    input  logic hint_backward,
    output logic taken
);
    pred_src_e src;

    // Choose the source of the prediction.
    always_comb begin
        if (!lk_valid)    src = SRC_NONE;
        else if (!lk_cond) src = SRC_UNCOND;
        else if (tbl_hit) src = SRC_TABLE;
        else              src = SRC_STATIC;
    end

    // Turn the chosen source into a direction.
    always_comb begin
        unique case (src)
            SRC_UNCOND: taken = 1'b1;
            SRC_TABLE:  taken = tbl_dir;
            SRC_STATIC: taken = hint_backward;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_hint_unit.sv
// Module: top of the last-outcome branch direction predictor.
// Lookups are answered combinationally. Conditional resolves update the
// table on the rising edge. Unconditional resolves are dropped.
// Assumes: synchronous active-low reset, ENTRIES a power of two.
module branch_hint_unit #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [ADDR_W-1:0] lk_target,
    input  logic              lk_cond,
    output logic              lk_taken,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_cond,
    input  logic              rs_taken
);
    logic tbl_hit;
    logic tbl_dir;
    logic hint_backward;
    logic tbl_wr;

    // Only conditional resolves allocate or update a slot.
    always_comb begin
        tbl_wr = rs_valid && rs_cond;
    end

    bhu_history_table #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_pc  (lk_pc),
        .rd_hit (tbl_hit),
        .rd_dir (tbl_dir),
        .wr_en  (tbl_wr),
        .wr_pc  (rs_pc),
        .wr_dir (rs_taken)
    );

    bhu_static_hint #(
        .ADDR_W (ADDR_W)
    ) u_hint (
        .pc       (lk_pc),
        .target   (lk_target),
        .backward (hint_backward)
    );

    bhu_select u_select (
        .lk_valid      (lk_valid),
        .lk_cond       (lk_cond),
        .tbl_hit       (tbl_hit),
        .tbl_dir       (tbl_dir),
        .hint_backward (hint_backward),
        .taken         (lk_taken)
    );

endmodule

// File: rtl/bhu_checker.sv
// Module: protocol and behaviour checks for branch_hint_unit, bound to it.
// Assumes: inputs are driven to known values while rst_n is low.
module bhu_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_pc,
    input logic [ADDR_W-1:0] lk_target,
    input logic              lk_cond,
    input logic              lk_taken,
    input logic              rs_valid,
    input logic [ADDR_W-1:0] rs_pc,
    input logic              rs_cond,
    input logic              rs_taken
);
    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_cond) |-> lk_taken); // R1

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_taken); // R9

    AST_RESOLVE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rs_valid && rs_cond) && lk_valid && lk_cond && (lk_pc == $past(rs_pc)))
        |-> (lk_taken == $past(rs_taken))); // R8

    AST_RESET_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && lk_valid && lk_cond) |-> (lk_taken == (lk_target < lk_pc))); // R7

endmodule

bind branch_hint_unit bhu_checker #(.ADDR_W(ADDR_W)) u_bhu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_pc     (lk_pc),
    .lk_target (lk_target),
    .lk_cond   (lk_cond),
    .lk_taken  (lk_taken),
    .rs_valid  (rs_valid),
    .rs_pc     (rs_pc),
    .rs_cond   (rs_cond),
    .rs_taken  (rs_taken)
);

// File: tb/test_branch_hint_unit.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a reference table kept in the bench.
module test_branch_hint_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int ENTRIES    = 64;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int TAG_W      = ADDR_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lk_valid;
    logic [ADDR_W-1:0] lk_pc;
    logic [ADDR_W-1:0] lk_target;
    logic              lk_cond;
    logic              lk_taken;
    logic              rs_valid;
    logic [ADDR_W-1:0] rs_pc;
    logic              rs_cond;
    logic              rs_taken;

    int vectors  = 0;
    int failures = 0;

    // Reference table, one slot per index.
    logic             m_valid [ENTRIES];
    logic [TAG_W-1:0] m_tag   [ENTRIES];
    logic             m_dir   [ENTRIES];

    branch_hint_unit #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_branch_hint_unit (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_target(lk_target),
        .lk_cond(lk_cond), .lk_taken(lk_taken),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_cond(rs_cond), .rs_taken(rs_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected prediction from the requirements and the reference table.
    function automatic logic expect_dir(logic v, logic [ADDR_W-1:0] pc,
                                        logic [ADDR_W-1:0] tgt, logic cnd);
        int unsigned idx;
        idx = int'(pc[IDX_W-1:0]);
        if (!v) return 1'b0;
        if (!cnd) return 1'b1;
        if (m_valid[idx] && m_tag[idx] == pc[ADDR_W-1:IDX_W]) return m_dir[idx];
        return tgt < pc;
    endfunction

    function automatic logic [ADDR_W-1:0] mk_pc(int unsigned tag, int unsigned idx);
        return (ADDR_W'(tag) << IDX_W) | ADDR_W'(idx);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
            m_dir[i]   = 1'b0;
        end
    endtask

    // One cycle: drive on falling edge, check before rising edge, update model at the edge.
    task automatic step(input logic lv, input logic [ADDR_W-1:0] lp,
                        input logic [ADDR_W-1:0] lt, input logic lc,
                        input logic rv, input logic [ADDR_W-1:0] rp,
                        input logic rc, input logic rt, input string req);
        logic exp;
        @(negedge clk);
        lk_valid = lv; lk_pc = lp; lk_target = lt; lk_cond = lc;
        rs_valid = rv; rs_pc = rp; rs_cond = rc; rs_taken = rt;
        #1;
        exp = expect_dir(lv, lp, lt, lc);
        vectors++;
        if (lk_taken !== exp) begin
            failures++;
            $display("FAIL %s pc=%h tgt=%h got %b exp %b", req, lp, lt, lk_taken, exp);
        end
        @(posedge clk);
        if (rv && rc) begin
            m_valid[int'(rp[IDX_W-1:0])] = 1'b1;
            m_tag[int'(rp[IDX_W-1:0])]   = rp[ADDR_W-1:IDX_W];
            m_dir[int'(rp[IDX_W-1:0])]   = rt;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 0; lk_pc = '0; lk_target = '0; lk_cond = 0;
        rs_valid = 0; rs_pc = '0; rs_cond = 0; rs_taken = 0;
        @(posedge clk);
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a, b, c;
        rst_n = 1'b0;
        model_clear();
        do_reset();

        // R9: an idle lookup predicts low
        step(0, 32'h100, 32'h10, 1, 0, '0, 0, 0, "R9");
        // R7 R3: after reset, backward conditional is taken
        step(1, 32'h2000, 32'h1000, 1, 0, '0, 0, 0, "R7 R3 backward");
        // R3: forward is not taken, and equal target is not taken
        step(1, 32'h2000, 32'h3000, 1, 0, '0, 0, 0, "R3 forward");
        step(1, 32'h2000, 32'h2000, 1, 0, '0, 0, 0, "R3 equal");
        // R1: unconditional forward is taken
        step(1, 32'h2000, 32'h9000, 0, 0, '0, 0, 0, "R1");

        // R6: an unconditional resolve leaves the slot empty
        a = mk_pc(5, 3);
        step(0, '0, '0, 0, 1, a, 0, 1, "R6 write");
        step(1, a, a + 32'h40, 1, 0, '0, 0, 0, "R6 forward still static");

        // R2 R8: a same-cycle resolve is unseen, then seen next cycle
        step(1, a, a + 32'h40, 1, 1, a, 1, 1, "R8 old value");
        step(1, a, a + 32'h40, 1, 0, '0, 0, 0, "R2 R8 new value taken");
        step(1, a, a - 32'h40, 1, 1, a, 1, 0, "R8 old taken");
        step(1, a, a - 32'h40, 1, 0, '0, 0, 0, "R2 backward follows not taken");

        // R4 R5: alias with another tag on the same index replaces the slot
        b = mk_pc(9, 3);
        step(1, b, b + 32'h40, 1, 0, '0, 0, 0, "R4 alias miss");
        step(0, '0, '0, 0, 1, b, 1, 1, "R5 alias write");
        step(1, b, b + 32'h40, 1, 0, '0, 0, 0, "R5 alias hit");
        step(1, a, a - 32'h40, 1, 0, '0, 0, 0, "R5 evicted uses static");
        // R6: unconditional resolve of the resident does not flip it
        step(0, '0, '0, 0, 1, b, 0, 0, "R6 write");
        step(1, b, b + 32'h40, 1, 0, '0, 0, 0, "R6 unchanged");
        // R4: a different index stays empty
        c = mk_pc(9, 4);
        step(1, c, c + 32'h40, 1, 0, '0, 0, 0, "R4 other index");

        // R7: reset mid-run forgets all slots
        do_reset();
        step(1, b, b + 32'h40, 1, 0, '0, 0, 0, "R7 cleared");

        // Seeded random traffic over a few tags and indexes.
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] p, t, r;
            p = mk_pc($urandom_range(3), $urandom_range(7));
            r = ($urandom_range(3) == 0) ? p : mk_pc($urandom_range(3), $urandom_range(7));
            case ($urandom_range(2))
                0: t = p + ADDR_W'($urandom_range(255));
                1: t = p - ADDR_W'($urandom_range(255));
                default: t = $urandom;
            endcase
            step($urandom_range(7) != 0, p, t, $urandom_range(4) != 0,
                 $urandom_range(1) == 1, r, $urandom_range(3) != 0,
                 $urandom_range(1) == 1, "R1 R2 R3 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule